// File: doc/BRIEF.md
# Conversion Start and Power Sequencer

This block decides when a delta-sigma converter core is powered and converting. It watches an asynchronous start pin, a speed/resolution select pin and a calibration request. It drives a power enable, a conversion-busy flag, a calibration-busy flag, a one-cycle strobe that marks the moment a result is written, and a one-cycle data-ready event that follows it. The length of each conversion and of a calibration comes from an internal cycle counter whose lengths are parameters in system-clock cycles. Simulation can therefore use short values and silicon can use real ones.

The start pin passes through a two-flop synchroniser and then a minimum-width qualifier, so glitches and short pulses are ignored. A qualified pulse that ends early still runs exactly one conversion, after which the block powers itself down. While the qualified start level stays high, conversions follow one another with no idle cycle. Leaving reset triggers a self-calibration. A calibration can also be requested later. Every calibration is followed by one conversion whose result is flagged ready, and that result is fully settled. A calibration request made during a conversion waits until that conversion ends.

Top module: `cvs_conv_sequencer`

## Requirements
- R1: During reset and after its release, `cal_busy` and `pwr_en` are high and `conv_busy`, `upd_stb` and `drdy_evt` are low. After the first rising clock edge that follows reset release, `cal_busy` stays high for exactly `CAL_CYC` clock cycles.
- R2: When a calibration ends, a conversion begins in the next cycle whatever the start pin does. That conversion produces one data-ready event.
- R3: The start pin is synchronised by two flops. A high pulse of fewer than `MIN_PULSE` clock cycles has no effect: `pwr_en` stays low. A pulse of `MIN_PULSE` cycles or more starts exactly one conversion, provided it is shorter than `MIN_PULSE` plus the conversion length.
- R4: A conversion keeps `conv_busy` high for `HS_CYC` cycles when `mode_in` is 1 and for `HR_CYC` cycles when `mode_in` is 0. The mode is sampled when the conversion starts, and a later change does not alter that conversion.
- R5: At the end of a conversion with no qualified start level, no pending start and no pending calibration, `pwr_en` falls in the next cycle and stays low.
- R6: If the qualified start level is still high in the last cycle of a conversion, the next conversion begins in the following cycle, so `conv_busy` shows no gap.
- R7: `upd_stb` is high for one cycle, the last cycle of each conversion. `drdy_evt` is high for the single cycle after it. Both conversion lengths are at least 2.
- R8: A `cal_req` pulse that arrives during a conversion does not shorten it. The calibration starts in the cycle after the conversion's last cycle.
- R9: A `cal_req` pulse while powered down starts a calibration in the next cycle. A `cal_req` during a calibration is ignored and does not lengthen it.
- R10: A pending calibration takes priority over a continuous conversion. It runs even while start is held high, and conversions resume after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Asynchronous start pin: high requests conversions, low allows shutdown |
| mode_in | input | 1 | 1 selects the short (high-speed) conversion, 0 the long (high-resolution) one |
| cal_req | input | 1 | Single-cycle self-calibration request |
| pwr_en | output | 1 | Core power enable, high while calibrating or converting |
| conv_busy | output | 1 | High during every cycle of a conversion |
| cal_busy | output | 1 | High during every cycle of a calibration |
| upd_stb | output | 1 | Result-write strobe on the last conversion cycle |
| drdy_evt | output | 1 | Data-ready event, one cycle after the write strobe |

## Verification
The bound checker checks several things on every cycle. Each conversion length matches the mode captured at its start. The end of a conversion leads to calibration, to the next conversion or to shutdown according to the pending requests. A conversion is never cut short, and data-ready always follows the write strobe. Other properties depend on how the start pin is driven over many cycles, so only the bench scenarios show them. These are the pulse-width boundary of the qualifier, the exact calibration length after reset, the count of conversions a given pulse width produces, and the handling of mid-conversion mode changes and repeated calibration requests.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_CAL  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  // Conversion length chosen by the speed select.
  function automatic int unsigned conv_len(input logic fast,
                                           input int unsigned hs,
                                           input int unsigned hr);
    return fast ? hs : hr;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Where the sequencer goes when a conversion finishes.
  function automatic seq_state_e after_conv(input logic cal_want,
                                            input logic start_want);
    if (cal_want)   return ST_CAL;
    if (start_want) return ST_CONV;
    return ST_OFF;
  endfunction

endpackage

// File: rtl/cvs_start_qual.sv
module cvs_start_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PULSE   = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  output logic start_q,
  output logic start_rise
);
  localparam int unsigned QW = $clog2(MIN_PULSE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [QW-1:0]          hi_cnt;
  logic                   q_prev;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= start_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      q_prev <= 1'b0;
    end else begin
      q_prev <= start_q;
      if (!sync_q[SYNC_STAGES-1])          hi_cnt <= '0;
      else if (hi_cnt != QW'(MIN_PULSE))   hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign start_q    = (hi_cnt == QW'(MIN_PULSE));
  assign start_rise = start_q & ~q_prev;
endmodule

// File: rtl/cvs_cycle_timer.sv
module cvs_cycle_timer #(
  parameter int unsigned CW      = 18,
  parameter int unsigned RST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          run;

  // The reset value covers the reset cycle itself, so the period
  // after release lasts RST_LEN full cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(RST_LEN);
      run <= 1'b1;
    end else if (load) begin
      cnt <= load_len - 1'b1;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/cvs_seq_fsm.sv
module cvs_seq_fsm
  import cvs_pkg::*;
#(
  parameter int unsigned CW      = 18,
  parameter int unsigned HS_CYC  = 10000,
  parameter int unsigned HR_CYC  = 60000,
  parameter int unsigned CAL_CYC = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_q,
  input  logic          start_rise,
  input  logic          mode_in,
  input  logic          cal_req,
  input  logic          t_done,
  output logic          t_load,
  output logic [CW-1:0] t_len,
  output logic          conv_load,
  output logic          start_want,
  output logic          cal_want,
  output logic          pwr_en,
  output logic          conv_busy,
  output logic          cal_busy,
  output logic          upd_stb,
  output logic          drdy_evt
);
  seq_state_e state, state_n;
  logic       start_pend, cal_pend, cal_load;

  assign start_want = start_q | start_pend;
  assign cal_want   = cal_pend | (cal_req & (state != ST_CAL));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_OFF: begin
        if (cal_want)        state_n = ST_CAL;
        else if (start_want) state_n = ST_CONV;
      end
      ST_CAL:  if (t_done) state_n = ST_CONV;
      ST_CONV: if (t_done) state_n = after_conv(cal_want, start_want);
      default: state_n = ST_OFF;
    endcase
  end

  assign conv_load = (state_n == ST_CONV) && ((state != ST_CONV) || t_done);
  assign cal_load  = (state_n == ST_CAL) && (state != ST_CAL);
  assign t_load    = conv_load | cal_load;
  assign t_len     = cal_load ? CW'(CAL_CYC) : CW'(conv_len(mode_in, HS_CYC, HR_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_CAL;
      start_pend <= 1'b0;
      cal_pend   <= 1'b0;
      drdy_evt   <= 1'b0;
    end else begin
      state    <= state_n;
      drdy_evt <= upd_stb;
      if (conv_load)       start_pend <= 1'b0;
      else if (start_rise) start_pend <= 1'b1;
      if (cal_load)                            cal_pend <= 1'b0;
      else if (cal_req && state == ST_CONV)    cal_pend <= 1'b1;
    end
  end

  assign pwr_en    = (state != ST_OFF);
  assign conv_busy = (state == ST_CONV);
  assign cal_busy  = (state == ST_CAL);
  assign upd_stb   = conv_busy & t_done;
endmodule

// File: rtl/cvs_conv_sequencer.sv
module cvs_conv_sequencer
  import cvs_pkg::*;
#(
  parameter int unsigned MIN_PULSE = 17,
  parameter int unsigned HS_CYC    = 10000,
  parameter int unsigned HR_CYC    = 60000,
  parameter int unsigned CAL_CYC   = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic mode_in,
  input  logic cal_req,
  output logic pwr_en,
  output logic conv_busy,
  output logic cal_busy,
  output logic upd_stb,
  output logic drdy_evt
);
  localparam int unsigned MAX_LEN = max3(HS_CYC, HR_CYC, CAL_CYC);
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  logic          start_q, start_rise;
  logic          t_done, t_load, conv_load;
  logic          start_want, cal_want;
  logic [CW-1:0] t_len;

  cvs_start_qual #(.SYNC_STAGES(2), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst_n(rst_n), .start_in(start_in),
    .start_q(start_q), .start_rise(start_rise)
  );

  cvs_cycle_timer #(.CW(CW), .RST_LEN(CAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_len(t_len), .done(t_done)
  );

  cvs_seq_fsm #(.CW(CW), .HS_CYC(HS_CYC), .HR_CYC(HR_CYC), .CAL_CYC(CAL_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_q(start_q), .start_rise(start_rise),
    .mode_in(mode_in), .cal_req(cal_req), .t_done(t_done),
    .t_load(t_load), .t_len(t_len), .conv_load(conv_load),
    .start_want(start_want), .cal_want(cal_want),
    .pwr_en(pwr_en), .conv_busy(conv_busy), .cal_busy(cal_busy),
    .upd_stb(upd_stb), .drdy_evt(drdy_evt)
  );
endmodule

// File: rtl/cvs_seq_checker.sv
module cvs_seq_checker #(
  parameter int unsigned HS_CYC = 10000,
  parameter int unsigned HR_CYC = 60000
) (
  input logic clk,
  input logic rst_n,
  input logic mode_in,
  input logic cal_req,
  input logic pwr_en,
  input logic conv_busy,
  input logic cal_busy,
  input logic upd_stb,
  input logic drdy_evt,
  input logic t_done,
  input logic conv_load,
  input logic start_want,
  input logic cal_want
);
  logic [31:0] run_cnt, exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      exp_len <= '0;
    end else begin
      if (conv_load) begin
        run_cnt <= '0;
        exp_len <= mode_in ? HS_CYC : HR_CYC;
      end else if (conv_busy) begin
        run_cnt <= run_cnt + 1;
      end
    end
  end

  AST_CAL_THEN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy && t_done |=> conv_busy);                                  // R2
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (run_cnt + 1 == exp_len));                              // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en && !start_want && !cal_req |=> !pwr_en);                    // R3
  AST_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !cal_want && !start_want |=> !pwr_en);                   // R5
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && !cal_want && start_want |=> conv_busy);                  // R6
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);                                              // R7
  AST_DRDY_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_evt |-> $past(upd_stb));                                       // R7
  AST_CONV_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && !upd_stb |=> conv_busy);                               // R8
  AST_CAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && cal_want |=> cal_busy);                                  // R10
endmodule

bind cvs_conv_sequencer cvs_seq_checker #(.HS_CYC(HS_CYC), .HR_CYC(HR_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .cal_req(cal_req),
  .pwr_en(pwr_en), .conv_busy(conv_busy), .cal_busy(cal_busy),
  .upd_stb(upd_stb), .drdy_evt(drdy_evt), .t_done(t_done),
  .conv_load(conv_load), .start_want(start_want), .cal_want(cal_want)
);

// File: tb/cvs_conv_sequencer_tb_top.sv
module cvs_conv_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MINP = 4;
  localparam int HS   = 20;
  localparam int HR   = 50;
  localparam int CAL  = 80;
  localparam int NVEC = 7;
  // mode, pulse width, expected conversions, expected busy cycles
  localparam int VEC [NVEC][4] = '{
    '{1, 3,  0, 0},
    '{1, 4,  1, 20},
    '{0, 4,  1, 50},
    '{1, 23, 1, 20},
    '{1, 24, 2, 40},
    '{0, 60, 2, 100},
    '{0, 1,  0, 0}
  };

  logic clk = 1'b0;
  logic rst_n, start_in, mode_in, cal_req;
  logic pwr_en, conv_busy, cal_busy, upd_stb, drdy_evt;
  int checks = 0, errors = 0, cyc = 0;
  int idx, n_busy, n_cal, n_drdy, n_upd, n_ord;
  int f_busy, l_busy, f_cal, f_upd;
  logic prev_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvs_conv_sequencer #(.MIN_PULSE(MINP), .HS_CYC(HS), .HR_CYC(HR), .CAL_CYC(CAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .mode_in(mode_in), .cal_req(cal_req),
    .pwr_en(pwr_en), .conv_busy(conv_busy), .cal_busy(cal_busy),
    .upd_stb(upd_stb), .drdy_evt(drdy_evt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    idx = 0; n_busy = 0; n_cal = 0; n_drdy = 0; n_upd = 0; n_ord = 0;
    f_busy = -1; l_busy = -1; f_cal = -1; f_upd = -1; prev_upd = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    idx++;
    if (conv_busy) begin n_busy++; if (f_busy < 0) f_busy = idx; l_busy = idx; end
    if (cal_busy)  begin n_cal++;  if (f_cal < 0) f_cal = idx; end
    if (upd_stb)   begin n_upd++;  if (f_upd < 0) f_upd = idx; end
    if (drdy_evt)  begin n_drdy++; if (prev_upd) n_ord++; end
    prev_upd = upd_stb;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 500 && !conv_busy; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_in = 1'b0; mode_in = 1'b1; cal_req = 1'b0;
    clr_mon();
    run(3);
    // R1: reset state
    chk(cal_busy === 1'b1, "R1 cal_busy in reset", int'(cal_busy), 1);
    chk(pwr_en === 1'b1, "R1 pwr_en in reset", int'(pwr_en), 1);
    chk({conv_busy, upd_stb, drdy_evt} === 3'b000, "R1 idle outputs in reset",
        int'({conv_busy, upd_stb, drdy_evt}), 0);
    rst_n = 1'b1;
    clr_mon();
    run(200);
    chk(n_cal == CAL, "R1 power-up calibration length", n_cal, CAL);
    chk(f_busy == CAL + 1, "R2 conversion follows calibration", f_busy, CAL + 1);
    chk(n_busy == HS && n_drdy == 1, "R2 one conversion after calibration", n_busy, HS);
    chk(n_upd == 1 && n_ord == 1, "R7 drdy one cycle after update", n_ord, 1);
    chk(pwr_en === 1'b0, "R5 shutdown after calibration conversion", int'(pwr_en), 0);

    // table of start pulses
    for (int v = 0; v < NVEC; v++) begin
      mode_in = VEC[v][0][0];
      clr_mon();
      start_in = 1'b1;
      run(VEC[v][1]);
      start_in = 1'b0;
      run(150);
      chk(n_drdy == VEC[v][2], $sformatf("R3 conversions for pulse %0d", VEC[v][1]), n_drdy, VEC[v][2]);
      chk(n_busy == VEC[v][3], $sformatf("R4 busy cycles vector %0d", v), n_busy, VEC[v][3]);
      chk(n_ord == n_drdy && n_upd == n_drdy, $sformatf("R7 strobe pairing vector %0d", v), n_ord, n_drdy);
      if (VEC[v][2] == 2)
        chk(l_busy - f_busy + 1 == n_busy, $sformatf("R6 no gap vector %0d", v), l_busy - f_busy + 1, n_busy);
      chk(pwr_en === 1'b0, $sformatf("R5 auto shutdown vector %0d", v), int'(pwr_en), 0);
    end

    // R4: mode change mid conversion
    mode_in = 1'b1; clr_mon();
    start_in = 1'b1; run(MINP); start_in = 1'b0;
    wait_busy(); run(3); mode_in = 1'b0;
    run(150);
    chk(n_busy == HS, "R4 mode sampled at start", n_busy, HS);

    // R8: calibration request during a conversion
    mode_in = 1'b1; clr_mon();
    start_in = 1'b1; run(MINP); start_in = 1'b0;
    wait_busy(); run(5);
    cal_req = 1'b1; step(); cal_req = 1'b0;
    run(250);
    chk(f_cal == f_upd + 1, "R8 calibration after conversion end", f_cal, f_upd + 1);
    chk(n_busy == 2 * HS && n_cal == CAL, "R8 conversion not shortened", n_busy, 2 * HS);
    chk(n_drdy == 2, "R8 data-ready count", n_drdy, 2);

    // R9: request while off, repeated during calibration
    clr_mon();
    cal_req = 1'b1; step(); cal_req = 1'b0;
    chk(f_cal == 1, "R9 calibration starts next cycle", f_cal, 1);
    run(10);
    cal_req = 1'b1; step(); cal_req = 1'b0;
    run(200);
    chk(n_cal == CAL, "R9 request during calibration ignored", n_cal, CAL);
    chk(n_busy == HS && pwr_en === 1'b0, "R9 single conversion then off", n_busy, HS);

    // R10 / R6: calibration while start held high
    clr_mon();
    start_in = 1'b1;
    wait_busy(); run(5);
    cal_req = 1'b1; step(); cal_req = 1'b0;
    run(200);
    chk(f_cal == f_upd + 1, "R10 calibration preempts continuous run", f_cal, f_upd + 1);
    chk(n_cal == CAL, "R10 calibration length", n_cal, CAL);
    chk(n_drdy >= 3, "R6 continuous conversions resume", n_drdy, 3);
    start_in = 1'b0;
    run(100);
    chk(pwr_en === 1'b0, "R5 stops after start low", int'(pwr_en), 0);
    chk(n_busy % HS == 0, "R4 every continuous conversion full length", n_busy % HS, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule